// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Slave

This block is the write-side front end of a small byte-addressed nonvolatile memory model that sits on a two-wire serial bus. The master drives the clock line. The block samples both bus lines on its own system clock. It recognises START and STOP conditions and shifts in bytes most significant bit first. It answers each accepted byte by pulling the data line low for the ninth clock. A write is made of three parts. The first is a select byte that names the device and carries the top three address bits. The second is an address byte that carries the low eight bits. The third is one or more data bytes.

Accepted data bytes go into a 16-byte row latch. The low four bits of the address pointer step through the row and wrap, and the row itself never changes. A write-control input blocks a write: when it is high, data bytes are refused with a NoACK. The latch is committed to the memory array only when the STOP arrives in the slot right after an acknowledge. A timed programming phase then starts, and during it the block ignores the bus, so a master finds out when the write is done by polling with the select byte. A tap port reads the array directly, so the contents of the model can be inspected.

The controller is a single state machine. Its states are IDLE, SEL, SEL_ACK, ADDR, ADDR_ACK, DATA, DATA_ACK and PROG. The transitions are:
- START moves any state except PROG to SEL.
- SEL goes to SEL_ACK when the select code matches, and back to IDLE when it does not.
- SEL_ACK goes to ADDR, ADDR goes to ADDR_ACK, and ADDR_ACK goes to DATA.
- DATA goes to DATA_ACK, and DATA_ACK returns to DATA.
- A STOP goes to PROG when it falls in the tenth-bit slot with data latched. Any other STOP goes to IDLE.
- PROG goes to IDLE when the programming timer expires.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After reset the block does not pull the data line, and it acknowledges nothing until a START is seen.
- R2: The select byte is acknowledged only when bits 7:4 equal 1010 and bit 0 (direction) is 0. Bits 3:1 of the select byte are address bits 10:8. A byte that does not match is left unacknowledged, and so is every later byte until the next START.
- R3: The address byte is always acknowledged, and its eight bits are address bits 7:0 of the first data byte.
- R4: With the write-control input low, each data byte is acknowledged and is written after programming. With it high, each data byte gets a NoACK and the addressed location keeps its old value.
- R5: One write accepts 1 to 16 data bytes. They are stored at consecutive addresses that start at the given address, and address bits 10:4 stay fixed.
- R6: The pointer advances only in address bits 3:0. A byte past the end of the row wraps to offset 0, and a 17th byte overwrites the first.
- R7: Programming starts only when a STOP arrives on the clock that follows the ninth clock of a data byte. A STOP inside a byte discards the latched bytes, and the device answers its select code at once, with the memory unchanged.
- R8: During programming the select code gets a NoACK. After the programming time the latched bytes are in the array and the select code is acknowledged again.
- R9: A START in the middle of a byte aborts the transfer and discards the latched bytes. The new transfer that follows it is handled normally.
- R10: An acknowledge drives the data line low from the fall of the eighth clock until the fall of the ninth. This covers the whole ninth high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wc_i | input | 1 | Write control, high blocks data bytes |
| sda_pull_o | output | 1 | High pulls the data line low (acknowledge) |
| tap_addr_i | input | ADDR_W | Array inspection address |
| tap_data_o | output | 8 | Array byte at the inspection address |

## Verification
A sweep of page writes covers lengths from 1 to 17 bytes. Each length uses its own row and its own start offset. This separates clean in-row writes from writes that wrap, and it shows the wrap overwrite once a 17th byte arrives. The select byte is tried with a wrong code and with the read direction, and these are compared with a matching code, to tell a refused byte from an accepted one. Two STOP placements are compared: a STOP in the tenth-bit slot and a STOP partway through a byte. Polling right after each STOP shows whether programming started. A repeated START partway through a byte, followed by a second write, shows that only the second write lands. The write-control input is tried high and low over the same location.

// File: rtl/eew_pkg.sv
package eew_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_PROG
    } eew_state_e;

endpackage

// File: rtl/eew_sync.sv
module eew_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/eew_line_events.sv
module eew_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
    // data edges while the clock stays high are bus conditions
    assign start_c  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_c   = scl_s && scl_q && !sda_q && sda_s;

endmodule

// File: rtl/eew_page_latch.sv
module eew_page_latch #(
    parameter int ROW_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [ROW_W-1:0]           wr_off,
    input  logic [7:0]                 wr_byte,
    output logic [(1<<ROW_W)-1:0][7:0] slot_data,
    output logic [(1<<ROW_W)-1:0]      slot_valid
);

    localparam int ROW_BYTES = 1 << ROW_W;

    generate
        for (genvar k = 0; k < ROW_BYTES; k++) begin : g_slot
            logic [7:0] data_q;
            logic       valid_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_q  <= '0;
                    valid_q <= 1'b0;
                end else if (clear) begin
                    valid_q <= 1'b0;
                end else if (wr_en && wr_off == ROW_W'(k)) begin
                    data_q  <= wr_byte;
                    valid_q <= 1'b1;
                end
            end

            assign slot_data[k]  = data_q;
            assign slot_valid[k] = valid_q;
        end
    endgenerate

endmodule

// File: rtl/eew_array.sv
module eew_array #(
    parameter int ADDR_W = 11,
    parameter int ROW_W  = 4
) (
    input  logic                       clk,
    input  logic                       commit,
    input  logic [ADDR_W-ROW_W-1:0]    row_idx,
    input  logic [(1<<ROW_W)-1:0][7:0] row_data,
    input  logic [(1<<ROW_W)-1:0]      row_valid,
    input  logic [ADDR_W-1:0]          tap_addr,
    output logic [7:0]                 tap_data
);

    localparam int MEM_BYTES = 1 << ADDR_W;
    localparam int ROW_BYTES = 1 << ROW_W;

    logic [7:0] cells [MEM_BYTES];

    // whole-row commit, only the slots that were loaded change
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int k = 0; k < ROW_BYTES; k++) begin
                if (row_valid[k]) begin
                    cells[{row_idx, ROW_W'(k)}] <= row_data[k];
                end
            end
        end
    end

    assign tap_data = cells[tap_addr];

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
    import eew_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         ADDR_W      = 11,
    parameter int         ROW_W       = 4,
    parameter int         PROG_CYCLES = 10000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wc_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] tap_addr_i,
    output logic [7:0]        tap_data_o
);

    localparam int HI_W      = ADDR_W - 8;
    localparam int ROW_IDX_W = ADDR_W - ROW_W;
    localparam int ROW_BYTES = 1 << ROW_W;
    localparam int CNT_W     = $clog2(PROG_CYCLES + 1);

    // ---------------- bus sampling ----------------
    logic [2:0] raw_in;
    logic [2:0] synced;
    logic       scl_s;
    logic       sda_s;
    logic       wc_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_c;
    logic       stop_c;

    assign raw_in = {wc_i, sda_i, scl_i};

    eew_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    assign scl_s = synced[0];
    assign sda_s = synced[1];
    assign wc_s  = synced[2];

    eew_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    // ---------------- controller state ----------------
    eew_state_e             state;
    eew_state_e             state_nx;
    logic [3:0]             bit_cnt;
    logic [7:0]             shreg;
    logic [HI_W-1:0]        sel_hi;
    logic [ROW_IDX_W-1:0]   row_q;
    logic [ROW_W-1:0]       ptr;
    logic [CNT_W-1:0]       prog_cnt;
    logic                   wc_q;

    logic [ROW_BYTES-1:0][7:0] latch_data;
    logic [ROW_BYTES-1:0]      latch_valid;

    logic                   byte_done;
    logic                   sel_match;
    logic [ADDR_W-1:0]      addr_full;
    logic                   shifting;
    logic                   accept;
    logic                   commit;
    logic                   stop_in_slot;
    logic                   latch_clear;

    assign byte_done    = scl_fall && (bit_cnt == 4'd8);
    assign sel_match    = (shreg[7:4] == DEV_CODE) && !shreg[0];
    assign addr_full    = {sel_hi, shreg};
    assign shifting     = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_DATA);
    assign accept       = (state == ST_DATA) && byte_done && !wc_s;
    assign commit       = (state == ST_PROG) && (prog_cnt == CNT_W'(PROG_CYCLES - 1));
    // one clock after the ninth, with at least one byte held
    assign stop_in_slot = (state == ST_DATA) && (bit_cnt == 4'd1) && (|latch_valid);
    assign latch_clear  = commit ||
                          ((state != ST_PROG) && (start_c || (stop_c && !stop_in_slot)));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (state == ST_PROG) begin
            if (commit) begin
                state_nx = ST_IDLE;
            end
        end else if (start_c) begin
            state_nx = ST_SEL;
        end else if (stop_c) begin
            state_nx = stop_in_slot ? ST_PROG : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_SEL:      if (byte_done) state_nx = sel_match ? ST_SEL_ACK : ST_IDLE;
                ST_SEL_ACK:  if (scl_fall)  state_nx = ST_ADDR;
                ST_ADDR:     if (byte_done) state_nx = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_nx = ST_DATA;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            sel_hi   <= '0;
            row_q    <= '0;
            ptr      <= '0;
            prog_cnt <= '0;
            wc_q     <= 1'b1;
        end else begin
            if (state == ST_PROG) begin
                prog_cnt <= prog_cnt + 1'b1;
            end else begin
                prog_cnt <= '0;
            end

            if ((state != ST_PROG) && start_c) begin
                bit_cnt <= '0;
            end else if (shifting && scl_rise) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (shifting && byte_done) begin
                bit_cnt <= '0;
            end

            if ((state == ST_SEL) && byte_done && sel_match) begin
                sel_hi <= shreg[HI_W:1];
            end

            if ((state == ST_ADDR) && byte_done) begin
                row_q <= addr_full[ADDR_W-1:ROW_W];
                ptr   <= addr_full[ROW_W-1:0];
            end

            if ((state == ST_DATA) && byte_done) begin
                wc_q <= wc_s;
            end

            if (accept) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        unique case (state)
            ST_SEL_ACK,
            ST_ADDR_ACK: sda_pull_o = 1'b1;
            ST_DATA_ACK: sda_pull_o = !wc_q;
            default:     sda_pull_o = 1'b0;
        endcase
    end

    // ---------------- row latch and array ----------------
    eew_page_latch #(
        .ROW_W (ROW_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (latch_clear),
        .wr_en      (accept),
        .wr_off     (ptr),
        .wr_byte    (shreg),
        .slot_data  (latch_data),
        .slot_valid (latch_valid)
    );

    eew_array #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W)
    ) u_array (
        .clk       (clk),
        .commit    (commit),
        .row_idx   (row_q),
        .row_data  (latch_data),
        .row_valid (latch_valid),
        .tap_addr  (tap_addr_i),
        .tap_data  (tap_data_o)
    );

endmodule

// File: rtl/eew_checker.sv
module eew_checker
    import eew_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input eew_state_e            state,
    input logic [3:0]            bit_cnt,
    input logic                  scl_fall,
    input logic                  wc_s,
    input logic                  accept,
    input logic                  commit,
    input logic [ROW_W-1:0]      ptr,
    input logic [(1<<ROW_W)-1:0] latch_valid,
    input logic                  sda_pull_o
);

    // bus released for the whole programming phase
    p_prog_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> !sda_pull_o);

    // timer expiry returns to idle
    p_prog_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_IDLE));

    // pointer moves by one inside the row, wrapping
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ptr == ROW_W'($past(ptr) + 1'b1)));

    // a blocked byte leaves the latch untouched
    p_blocked_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA) && scl_fall && (bit_cnt == 4'd8) && wc_s)
        |=> (latch_valid == $past(latch_valid)));

    // programming entered only from the tenth-bit slot with data held
    p_stop_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PROG) && ($past(state) != ST_PROG))
        |-> (($past(state) == ST_DATA) && ($past(bit_cnt) == 4'd1) && ($past(latch_valid) != '0)));

    // a fresh frame starts with an empty latch
    p_frame_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEL) && ($past(state) != ST_SEL)) |-> (latch_valid == '0));

endmodule

bind eeprom_wr_slave eew_checker #(
    .ROW_W (ROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .bit_cnt     (bit_cnt),
    .scl_fall    (scl_fall),
    .wc_s        (wc_s),
    .accept      (accept),
    .commit      (commit),
    .ptr         (ptr),
    .latch_valid (latch_valid),
    .sda_pull_o  (sda_pull_o)
);

// File: tb/eeprom_wr_slave_test.sv
module eeprom_wr_slave_test;

    localparam int ADDR_W = 11;
    localparam int PROG   = 400;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              wc    = 1'b0;
    logic              sda_pull;
    logic              sda_line;
    logic [ADDR_W-1:0] tap_addr = '0;
    logic [7:0]        tap_data;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    logic [7:0] ref_mem [1<<ADDR_W];
    bit         known   [1<<ADDR_W];

    assign sda_line = sda_m & ~sda_pull;

    eeprom_wr_slave #(
        .ADDR_W      (ADDR_W),
        .PROG_CYCLES (PROG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .wc_i       (wc),
        .sda_pull_o (sda_pull),
        .tap_addr_i (tap_addr),
        .tap_data_o (tap_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic bus_start();
        tick(3); sda_m = 1'b1; tick(7); scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(3); sda_m = 1'b0; tick(7); scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic bit_out(input bit b);
        tick(3); sda_m = b; tick(7); scl_m = 1'b1; tick(10); scl_m = 1'b0;
    endtask

    task automatic byte_raw(input logic [7:0] b, output bit pre, output bit ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        tick(3); sda_m = 1'b1; tick(7);
        pre = sda_pull;
        scl_m = 1'b1; tick(5);
        ack = sda_pull;
        tick(5); scl_m = 1'b0;
    endtask

    task automatic byte_chk(input logic [7:0] b, input bit exp, input string req);
        bit p, a;
        byte_raw(b, p, a);
        check(a == exp, req, a, exp);
        if (exp) check(p == 1'b1, "R10", p, 1);
    endtask

    function automatic logic [7:0] sel_byte(input logic [ADDR_W-1:0] a, input bit rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    task automatic poll(output int nacks);
        bit p, a;
        nacks = 0;
        for (int t = 0; t < 60; t++) begin
            bus_start();
            byte_raw(sel_byte('0, 1'b0), p, a);
            bus_stop();
            if (a) break;
            nacks++;
        end
    endtask

    task automatic page_write(input logic [ADDR_W-1:0] addr, input int len,
                              input logic [7:0] seed, input string req);
        logic [7:0]        d;
        logic [ADDR_W-1:0] loc;
        bus_start();
        byte_chk(sel_byte(addr, 1'b0), 1'b1, "R2");
        byte_chk(addr[7:0], 1'b1, "R3");
        for (int i = 0; i < len; i++) begin
            d = seed + 8'(i * 37);
            byte_chk(d, !wc, wc ? "R4" : req);
            if (!wc) begin
                loc = {addr[10:4], 4'(addr[3:0] + 4'(i))};
                ref_mem[loc] = d;
                known[loc]   = 1'b1;
            end
        end
        bus_stop();
    endtask

    task automatic check_mem(input logic [ADDR_W-1:0] a, input string req);
        tap_addr = a;
        tick(1);
        if (known[a]) check(tap_data == ref_mem[a], req, tap_data, ref_mem[a]);
    endtask

    task automatic check_row(input logic [ADDR_W-1:0] a, input string req);
        for (int k = 0; k < 16; k++) check_mem({a[10:4], 4'(k)}, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        bit p, a;
        logic [ADDR_W-1:0] ad;

        tick(10);
        rst_n = 1'b1;
        tick(5);
        check(sda_pull == 1'b0, "R1", sda_pull, 0);

        // R2: wrong code, read direction, and bytes after a refused select
        bus_start();
        byte_chk(8'hB0, 1'b0, "R2");
        byte_chk(8'h00, 1'b0, "R2");
        bus_stop();
        bus_start();
        byte_chk(sel_byte(11'h123, 1'b1), 1'b0, "R2");
        bus_stop();

        // single byte write, busy polling
        page_write(11'h123, 1, 8'h5A, "R4");
        poll(n);
        check(n >= 1, "R8", n, 1);
        check(n <= 4, "R8", n, 4);
        check_mem(11'h123, "R3");

        // blocked write leaves the byte and starts no programming
        wc = 1'b1;
        page_write(11'h123, 1, 8'hC3, "R4");
        poll(n);
        check(n == 0, "R4", n, 0);
        check_mem(11'h123, "R4");
        wc = 1'b0;

        // page length sweep with varying start offsets
        for (int len = 1; len <= 17; len++) begin
            ad = {7'(len * 5), 4'(len * 7)};
            page_write(ad, len, 8'(len * 11), (4'(len * 7) + len > 16) ? "R6" : "R5");
            poll(n);
            check(n >= 1, "R8", n, 1);
            check_row(ad, (4'(len * 7) + len > 16) ? "R6" : "R5");
        end

        // R7: STOP inside a byte discards
        page_write(11'h2A5, 2, 8'h11, "R5");
        poll(n);
        bus_start();
        byte_chk(sel_byte(11'h2A5, 1'b0), 1'b1, "R7");
        byte_chk(8'hA5, 1'b1, "R7");
        byte_chk(8'h99, 1'b1, "R7");
        byte_chk(8'h77, 1'b1, "R7");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        poll(n);
        check(n == 0, "R7", n, 0);
        check_mem(11'h2A5, "R7");
        check_mem(11'h2A6, "R7");

        // R9: repeated START mid-byte aborts the first transfer
        page_write(11'h3D0, 1, 8'hA0, "R5");
        poll(n);
        bus_start();
        byte_chk(sel_byte(11'h3D0, 1'b0), 1'b1, "R9");
        byte_chk(8'hD0, 1'b1, "R9");
        byte_chk(8'h55, 1'b1, "R9");
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_start();
        byte_chk(sel_byte(11'h3D8, 1'b0), 1'b1, "R9");
        byte_chk(8'hD8, 1'b1, "R9");
        byte_chk(8'h66, 1'b1, "R9");
        bus_stop();
        ref_mem[11'h3D8] = 8'h66;
        known[11'h3D8]   = 1'b1;
        poll(n);
        check(n >= 1, "R9", n, 1);
        check_mem(11'h3D0, "R9");
        check_mem(11'h3D8, "R9");

        // idle again after all traffic
        bus_start();
        byte_raw(sel_byte(11'h000, 1'b0), p, a);
        bus_stop();
        check(a == 1'b1, "R8", a, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule